// File: doc/BRIEF.md
# Programmable Sample Clock Divider

This block derives a slow sample or framing clock from a fast input clock. It divides the input clock by a programmable integer and drives one output. A second programmable field sets how many input cycles of each output period the output stays high, so the duty cycle can be shaped, for example to frame left and right audio channels. A divide field of zero stops the output and holds it low.

Two static encodings are offered through the `ONE_BASED` parameter. In zero-based mode a field value `v` means `v + 1` cycles. In one-based mode the value is used as it is. Software writes both fields through a plain write port made of two strobes and one shared data bus. A new divide or high-time value written while the output runs waits in its field register and is taken up only when the current output period ends, so no output period is ever cut short. When the output is stopped and a nonzero divide value is written, a fresh period starts at once, beginning with its high phase.

Top module: `sample_clk_div`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge of `clk`) clears the divide field and the high-time field to 0, so `clkOut` is low during reset and stays low after it until a nonzero divide value is written.
- R2: While the divide value in use is 0, `clkOut` is held low with no edges. Writing 0 to the divide field while running stops the output at the end of the current period.
- R3: With `ONE_BASED` = 0 and divide field `d` >= 1, the output period is `d + 1` input clock cycles.
- R4: With `ONE_BASED` = 1 and divide field `d` >= 1, the output period is `d` input clock cycles.
- R5: With `ONE_BASED` = 0, the output is high for the first `h + 1` input cycles of each period, where `h` is the high-time field.
- R6: With `ONE_BASED` = 1, the output is high for the first `h` input cycles of each period. `h` = 0 keeps the output low.
- R7: When the high length is equal to or greater than the period length (`h` >= `d` in either mode, including values above `d`), the output is high for the whole period, that is, constantly high.
- R8: A divide or high-time value written while the output runs leaves the current period unchanged. The new values take effect at the first cycle of the next period.
- R9: When the divide value in use is 0 and a nonzero value lands in the divide field (write strobe sampled at edge k), `clkOut` is still low after edge k. It is high after edge k+1 (the first cycle of a new period), provided the high length is at least 1.
- R10: Division ranges over `2..2^DIV_W` in zero-based mode and `1..2^DIV_W - 1` in one-based mode. The all-ones field gives the maximum and field value 1 gives the minimum. With one-based field 1 the output is constant (high if `h` >= 1, low if `h` = 0).
- R11: `wrDiv` loads `wrData` into the divide field and `wrHigh` loads it into the high-time field at the same edge. Both may be asserted together. A field whose strobe is low keeps its value. Writing the high-time field while stopped keeps the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| wrDiv | input | 1 | Write strobe for the divide field |
| wrHigh | input | 1 | Write strobe for the high-time field |
| wrData | input | DIV_W | Write data shared by both fields |
| clkOut | output | 1 | Divided clock, driven from a register |

## Verification
A corrupted period counter or a wrong active copy of the fields shows up at `clkOut` within one output period, at most `2^DIV_W` input cycles. It appears as a wrong distance between rising edges or a wrong high width. A field taken up at the wrong moment shows as a period of mixed length around the write. The bench therefore checks the exact cycle-by-cycle waveform around a start from the stopped state and around a mid-period write. It measures edge-to-edge period and high width for random settings in both encodings. It also checks the constant-output corners (stopped, fully high, one-based division by one) over windows longer than the largest period.

// File: rtl/scd_pkg.sv
package scd_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic load;  // start a new period with the field values
    logic step;  // advance the period counter
  } seq_ctrl_t;

endpackage

// File: rtl/scd_encode.sv
// Maps field values to cycle counts for the selected encoding.
module scd_encode #(
  parameter int DIV_W     = 4,
  parameter bit ONE_BASED = 1'b0
) (
  input  logic [DIV_W-1:0] divVal,
  input  logic [DIV_W-1:0] highVal,
  output logic [DIV_W:0]   periodLen,
  output logic [DIV_W:0]   highLen
);

  localparam int CW = DIV_W + 1;

  generate
    if (ONE_BASED) begin : g_one
      assign periodLen = {1'b0, divVal};
      assign highLen   = {1'b0, highVal};
    end else begin : g_zero
      assign periodLen = {1'b0, divVal} + CW'(1);
      assign highLen   = {1'b0, highVal} + CW'(1);
    end
  endgenerate

endmodule

// File: rtl/scd_ctrl.sv
// Field registers and period-boundary sequencing.
module scd_ctrl
  import scd_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrDiv,
  input  logic             wrHigh,
  input  logic [DIV_W-1:0] wrData,
  input  logic             running,
  input  logic             atLast,
  output logic [DIV_W-1:0] divField,
  output logic [DIV_W-1:0] highField,
  output seq_ctrl_t        ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      divField  <= '0;
      highField <= '0;
    end else begin
      if (wrDiv)  divField  <= wrData;
      if (wrHigh) highField <= wrData;
    end
  end

  // A running output reloads only on its last cycle; a stopped one
  // restarts as soon as the divide field is nonzero.
  always_comb begin
    ctrl.load = running ? atLast : (divField != '0);
    ctrl.step = running && !atLast;
  end

  // R11
  div_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrDiv |=> (divField == $past(wrData)));

  // R11
  high_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrHigh |=> (highField == $past(wrData)));

  // R11
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrDiv |=> $stable(divField));

endmodule

// File: rtl/scd_datapath.sv
// Active settings, period counter and registered output.
module scd_datapath
  import scd_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter bit ONE_BASED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_ctrl_t        ctrl,
  input  logic [DIV_W-1:0] divField,
  input  logic [DIV_W-1:0] highField,
  output logic             running,
  output logic             atLast,
  output logic             clkOut
);

  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] divAct, highAct, nDiv, nHigh;
  logic [CW-1:0]    cnt, nCnt;
  logic [CW-1:0]    actLen, actOn, nxtLen, nxtOn;
  logic             outQ;

  scd_encode #(.DIV_W(DIV_W), .ONE_BASED(ONE_BASED)) encAct_i (
    .divVal(divAct), .highVal(highAct), .periodLen(actLen), .highLen(actOn)
  );

  scd_encode #(.DIV_W(DIV_W), .ONE_BASED(ONE_BASED)) encNxt_i (
    .divVal(nDiv), .highVal(nHigh), .periodLen(nxtLen), .highLen(nxtOn)
  );

  assign running = (divAct != '0);
  assign atLast  = (cnt == actLen - CW'(1));

  always_comb begin
    nDiv  = divAct;
    nHigh = highAct;
    nCnt  = cnt;
    if (ctrl.load) begin
      nDiv  = divField;
      nHigh = highField;
      nCnt  = '0;
    end else if (ctrl.step) begin
      nCnt = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divAct  <= '0;
      highAct <= '0;
      cnt     <= '0;
      outQ    <= 1'b0;
    end else begin
      divAct  <= nDiv;
      highAct <= nHigh;
      cnt     <= nCnt;
      outQ    <= (nDiv != '0) && (nCnt < nxtOn);
    end
  end

  assign clkOut = outQ;

  // nxtLen is only observed by the range check below
  logic lenOk;
  assign lenOk = (nCnt < nxtLen) || (nDiv == '0);

  // R3 R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < actLen));

  // R3 R4
  next_range_chk: assert property (@(posedge clk) disable iff (rst)
    lenOk);

  // R2
  gated_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && divField == '0) |=> !clkOut);

  // R8
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !atLast) |=> ($stable(divAct) && $stable(highAct)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && divField != '0) |=> (running && cnt == '0));

  // R7
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (running && actOn >= actLen) |-> clkOut);

endmodule

// File: rtl/sample_clk_div.sv
module sample_clk_div
  import scd_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter bit ONE_BASED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrDiv,
  input  logic             wrHigh,
  input  logic [DIV_W-1:0] wrData,
  output logic             clkOut
);

  seq_ctrl_t        ctrl;
  logic [DIV_W-1:0] divField, highField;
  logic             running, atLast;

  scd_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rst(rst), .wrDiv(wrDiv), .wrHigh(wrHigh), .wrData(wrData),
    .running(running), .atLast(atLast),
    .divField(divField), .highField(highField), .ctrl(ctrl)
  );

  scd_datapath #(.DIV_W(DIV_W), .ONE_BASED(ONE_BASED)) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .divField(divField), .highField(highField),
    .running(running), .atLast(atLast), .clkOut(clkOut)
  );

endmodule

// File: tb/sample_clk_div_tb_top.sv
`timescale 1ns/1ps
module sample_clk_div_tb_top;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrDiv = 1'b0, wrHigh = 1'b0;
  logic [W-1:0] wrData = '0;
  logic clkZero, clkOne;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sample_clk_div #(.DIV_W(W), .ONE_BASED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .wrDiv(wrDiv), .wrHigh(wrHigh),
    .wrData(wrData), .clkOut(clkZero)
  );

  sample_clk_div #(.DIV_W(W), .ONE_BASED(1'b1)) dutOne_i (
    .clk(clk), .rst(rst), .wrDiv(wrDiv), .wrHigh(wrHigh),
    .wrData(wrData), .clkOut(clkOne)
  );

  function automatic int expPeriod(bit one, int d);
    return one ? d : d + 1;
  endfunction

  function automatic int expHigh(bit one, int h);
    return one ? h : h + 1;
  endfunction

  function automatic bit outOf(bit one);
    return one ? clkOne : clkZero;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeDiv(int v);
    @(negedge clk); wrDiv = 1'b1; wrData = W'(v);
    @(negedge clk); wrDiv = 1'b0;
  endtask

  task automatic writeHigh(int v);
    @(negedge clk); wrHigh = 1'b1; wrData = W'(v);
    @(negedge clk); wrHigh = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic expectConst(bit one, bit v, int n, string req);
    int bad = 0;
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outOf(one) != v) begin bad++; seen = outOf(one); end
    end
    check(bad == 0, req, bad == 0 ? int'(v) : seen, int'(v));
  endtask

  // Measures one full period from a rising edge to the next rising edge
  task automatic measure(bit one, output int hiW, output int per);
    bit prev, cur, inHigh, found;
    hiW = -1; per = -1;
    prev = outOf(one); found = 1'b0;
    for (int t = 0; t < 100 && !found; t++) begin
      @(negedge clk); cur = outOf(one);
      if (cur && !prev) found = 1'b1;
      prev = cur;
    end
    if (!found) return;
    hiW = 1; per = 1; inHigh = 1'b1; found = 1'b0;
    for (int t = 0; t < 100 && !found; t++) begin
      @(negedge clk); cur = outOf(one);
      if (cur && !prev) found = 1'b1;
      else begin
        per++;
        if (cur && inHigh) hiW++;
        if (!cur) inHigh = 1'b0;
      end
      prev = cur;
    end
    if (!found) per = -1;
  endtask

  task automatic measureCheck(bit one, int d, int h, string reqP, string reqH);
    int hw, pr;
    measure(one, hw, pr);
    measure(one, hw, pr);
    check(pr == expPeriod(one, d), reqP, pr, expPeriod(one, d));
    check(hw == expHigh(one, h), reqH, hw, expHigh(one, h));
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(clkZero == 1'b0, "R1 zero-based in reset", clkZero, 0);
    check(clkOne == 1'b0, "R1 one-based in reset", clkOne, 0);
    rst = 1'b0;
  endtask

  initial begin
    bit expZ[10];
    bit expO[10];
    void'($urandom(32'd4242));
    expZ = '{0, 1, 1, 0, 0, 0, 1, 1, 0, 1};
    expO = '{0, 1, 0, 0, 0, 1, 0, 1, 0, 1};

    doReset();
    expectConst(0, 1'b0, 20, "R1 zero-based after reset");
    expectConst(1, 1'b0, 20, "R1 one-based after reset");

    // R11: high-time write while stopped keeps output low
    writeHigh(1);
    expectConst(0, 1'b0, 10, "R11 zero-based high write while stopped");

    // R9 start from stopped, then R8 divide change at cycle n1
    @(negedge clk); wrDiv = 1'b1; wrData = W'(4);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(clkZero == expZ[i], i < 2 ? "R9 zero-based start" : "R8 zero-based update",
            clkZero, expZ[i]);
      check(clkOne == expO[i], i < 2 ? "R9 one-based start" : "R8 one-based update",
            clkOne, expO[i]);
      if (i == 0) wrDiv = 1'b0;
      if (i == 1) begin wrDiv = 1'b1; wrData = W'(2); end
      if (i == 2) wrDiv = 1'b0;
    end

    // Random settings: R3 R4 R5 R6
    for (int it = 0; it < 30; it++) begin
      int d, h;
      d = $urandom_range(15, 2);
      h = $urandom_range(d - 1, 1);
      writeDiv(d);
      writeHigh(h);
      measureCheck(0, d, h, "R3 period", "R5 high");
      measureCheck(1, d, h, "R4 period", "R6 high");
    end

    // R11 + R7: both strobes at once, h == d
    @(negedge clk); wrDiv = 1'b1; wrHigh = 1'b1; wrData = W'(3);
    @(negedge clk); wrDiv = 1'b0; wrHigh = 1'b0;
    settle();
    expectConst(0, 1'b1, 30, "R7 R11 zero-based h==d");
    expectConst(1, 1'b1, 30, "R7 R11 one-based h==d");

    // R7: high field beyond the divide field
    writeDiv(2); writeHigh(15); settle();
    expectConst(0, 1'b1, 30, "R7 zero-based h>d");
    expectConst(1, 1'b1, 30, "R7 one-based h>d");

    // R6: one-based h=0 stays low, zero-based still toggles
    writeDiv(4); writeHigh(0); settle();
    expectConst(1, 1'b0, 30, "R6 one-based h=0");
    measureCheck(0, 4, 0, "R3 period h=0", "R5 high h=0");

    // R10: maximum division
    writeHigh(1); writeDiv(15);
    measureCheck(0, 15, 1, "R10 zero-based max period", "R10 zero-based max high");
    measureCheck(1, 15, 1, "R10 one-based max period", "R10 one-based max high");

    // R10: minimum division
    writeDiv(1); writeHigh(0); settle();
    measureCheck(0, 1, 0, "R10 zero-based min period", "R10 zero-based min high");
    expectConst(1, 1'b0, 30, "R10 one-based div1 h=0");
    writeHigh(1); settle();
    expectConst(1, 1'b1, 30, "R10 one-based div1 h=1");

    // R2: writing zero stops the output
    writeDiv(5); writeHigh(2); settle();
    writeDiv(0);
    repeat (20) @(negedge clk);
    expectConst(0, 1'b0, 50, "R2 zero-based gated");
    expectConst(1, 1'b0, 50, "R2 one-based gated");

    // R1: reset while running clears the fields
    writeDiv(3); writeHigh(1); settle();
    doReset();
    expectConst(0, 1'b0, 20, "R1 zero-based after mid-run reset");
    writeHigh(2);
    expectConst(1, 1'b0, 20, "R1 one-based divide field cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule